// File: doc/BRIEF.md
# Oversampling Serial Receiver with Start Qualification

This block is the front end of an asynchronous serial receiver. It samples the receive line sixteen times per bit, using an enable strobe from an external baud divider. It vets every start edge with three verification samples, decides each data and stop bit by a three-sample majority, and reports the received word with noise and framing flags. Frames carry 8 or 9 data bits, least significant bit first, followed by a single stop bit.

The block has two restart rules. After a frame whose stop bit reads 0 but whose data is not all zero, the receiver treats the line as if a stop bit had arrived. It accepts a low line as the next start edge at the first sample after the stop bit ends, and not earlier. After a break, which is a frame that reads 0 from the start bit through the stop bit, it reports the break and then ignores the line until it has sampled a 1.

Top module: `uart_rx_qual`

## Requirements
- R1: When the synchronised line is first sampled 0 by an armed receiver, that sample is phase 0. Phases 3, 5 and 7 are the verification samples. The start is kept when at least two of them read 0. Otherwise the receiver returns to idle, gives no strobe, and must see the line at 1 before it looks for a start again.
- R2: An accepted start with any verification sample at 1 sets `noise_err` for that frame.
- R3: If the three samples of any data bit or of the stop bit do not all agree, `noise_err` is set for that frame.
- R4: Data bits are taken least significant first. With `nine_bit`=0 there are 8 bits and `rx_data[8]` is 0. With `nine_bit`=1 there are 9 bits.
- R5: `rx_ready` is high for exactly one clock, in the clock after the sample at phase 15 of the stop bit. `rx_data`, `noise_err` and `frame_err` change only together with `rx_ready` and hold their values until the next strobe.
- R6: `frame_err` is set when the stop bit's majority reads 0.
- R7: A break raises `rx_ready` with `frame_err`=1 and `rx_data`=0. A break is 10 zero bits with `nine_bit`=0, or 11 with `nine_bit`=1.
- R8: After a framing error that is not a break, a line that is low at the first sample after the stop bit is taken as a start edge, so a back-to-back frame is received correctly.
- R9: After a break, a line that stays low produces no further frame. A start is recognised only after a sample at 1.
- R10: Each bit's value is the majority of its samples at phases 8, 9 and 10. Samples at other phases do not affect the data or the noise flag.
- R11: During reset, and after it until the first strobe, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | One-clock strobe at 16 times the bit rate |
| rxd | input | 1 | Raw asynchronous receive line |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_data | output | 9 | Received word, zero-extended in 8-bit mode |
| rx_ready | output | 1 | One-clock pulse when a frame completes |
| noise_err | output | 1 | Noise flag for the last frame |
| frame_err | output | 1 | Framing-error flag for the last frame |

## Verification
Two cases can land on the same stop-bit sample. In the first, a framing-error report falls in the same cycle as the re-arming for a start that is already under way. The bench provokes this by sending a frame whose stop bit is low and following it at once with a low start bit. It then checks that both frames arrive, with the flag on the first frame only. In the second, a break report falls in the same cycle as the disarming. The bench holds the line low well past the break and checks that exactly one strobe appears, carrying a framing error and zero data. Other frames carry single flipped samples, placed inside and outside the voting windows, which separate noise from valid decisions.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the oversampling receiver.
// Assumes nothing beyond IEEE 1800-2017 enums.
package uart_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
// Module: two-flop synchroniser for the asynchronous receive line.
// Assumes the idle line level is 1, which is also the reset value.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_vote.sv
// Module: three-sample shift register and vote logic.
// Shifts in on cap. The vote covers the two stored samples plus the
// current sample, so a decision can be made in the cycle of the third capture.
module uart_rx_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic din,
    output logic maj,
    output logic all_zero,
    output logic mixed
);
    logic [1:0] hist;
    logic [2:0] trio;

    // Keep the two most recent captured samples.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist <= 2'b11;
        else if (cap) hist <= {hist[0], din};
    end

    // Majority and agreement over the current trio.
    always_comb begin
        trio     = {hist, din};
        maj      = (trio[0] & trio[1]) | (trio[0] & trio[2]) | (trio[1] & trio[2]);
        all_zero = (trio == 3'b000);
        mixed    = (trio != 3'b000) && (trio != 3'b111);
    end
endmodule

// File: rtl/uart_rx_fsm.sv
// Module: frame state machine, phase and bit counters, data shifter, flags.
// Assumes sample_en pulses OVS times per bit and nine_bit is stable during a frame.
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              line,
    input  logic              nine_bit,
    input  logic              maj,
    input  logic              all_zero,
    input  logic              mixed,
    output logic              cap,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              noise_err,
    output logic              frame_err,
    output logic              armed,
    output logic              busy
);
    localparam int PH_W = $clog2(OVS);
    localparam int BI_W = $clog2(DATA_W + 1);
    localparam logic [PH_W-1:0] PH_V0   = PH_W'(OVS / 4 - 1);
    localparam logic [PH_W-1:0] PH_V1   = PH_W'(OVS / 4 + 1);
    localparam logic [PH_W-1:0] PH_V2   = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0] PH_D0   = PH_W'(OVS / 2);
    localparam logic [PH_W-1:0] PH_D2   = PH_W'(OVS / 2 + 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

    rx_state_e         state;
    logic [PH_W-1:0]   phase;
    logic [BI_W-1:0]   bit_idx;
    logic [BI_W-1:0]   last_bit;
    logic [DATA_W-1:0] shreg;
    logic              noise_acc;
    logic              seen_one;
    logic              stop_val;
    logic              in_start_win;
    logic              in_bit_win;

    // Select the capture phases for the current state.
    always_comb begin
        in_start_win = (state == RX_START) &&
                       (phase == PH_V0 || phase == PH_V1 || phase == PH_V2);
        in_bit_win   = (state == RX_DATA || state == RX_STOP) &&
                       (phase >= PH_D0) && (phase <= PH_D2);
        cap          = sample_en && (in_start_win || in_bit_win);
        last_bit     = nine_bit ? BI_W'(DATA_W - 1) : BI_W'(DATA_W - 2);
        busy         = (state != RX_IDLE);
    end

    // Frame sequencing, bit assembly and the restart rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            phase     <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            noise_acc <= 1'b0;
            seen_one  <= 1'b0;
            stop_val  <= 1'b1;
            armed     <= 1'b0;
            rx_data   <= '0;
            rx_ready  <= 1'b0;
            noise_err <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_ready <= 1'b0;
            if (sample_en) begin
                unique case (state)
                    RX_IDLE: begin
                        if (line) begin
                            armed <= 1'b1;
                        end else if (armed) begin
                            state     <= RX_START;
                            phase     <= PH_W'(1);
                            noise_acc <= 1'b0;
                            seen_one  <= 1'b0;
                            shreg     <= '0;
                        end
                    end
                    RX_START: begin
                        phase <= phase + 1'b1;
                        if (phase == PH_V2) begin
                            if (maj) begin
                                state <= RX_IDLE;
                                armed <= 1'b0;
                            end else begin
                                noise_acc <= !all_zero;
                            end
                        end
                        if (phase == PH_LAST) begin
                            state   <= RX_DATA;
                            bit_idx <= '0;
                        end
                    end
                    RX_DATA: begin
                        phase <= phase + 1'b1;
                        if (phase == PH_D2) begin
                            noise_acc <= noise_acc | mixed;
                            seen_one  <= seen_one | maj;
                            if (nine_bit) shreg <= {maj, shreg[DATA_W-1:1]};
                            else          shreg <= {1'b0, maj, shreg[DATA_W-2:1]};
                        end
                        if (phase == PH_LAST) begin
                            if (bit_idx == last_bit) state <= RX_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        phase <= phase + 1'b1;
                        if (phase == PH_D2) begin
                            noise_acc <= noise_acc | mixed;
                            stop_val  <= maj;
                        end
                        if (phase == PH_LAST) begin
                            state     <= RX_IDLE;
                            rx_ready  <= 1'b1;
                            rx_data   <= shreg;
                            noise_err <= noise_acc;
                            frame_err <= !stop_val;
                            armed     <= stop_val | seen_one;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_qual.sv
// Module: top of the oversampling receiver with start qualification.
// Assumes sample_en is a one-clock pulse at 16x the bit rate and rxd idles high.
module uart_rx_qual #(
    parameter int OVS    = 16,
    parameter int DATA_W = 9,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rxd,
    input  logic              nine_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              noise_err,
    output logic              frame_err
);
    logic line_s;
    logic cap;
    logic maj;
    logic all_zero;
    logic mixed;
    logic armed;
    logic busy;

    uart_rx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    uart_rx_vote u_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .din     (line_s),
        .maj     (maj),
        .all_zero(all_zero),
        .mixed   (mixed)
    );

    uart_rx_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .line     (line_s),
        .nine_bit (nine_bit),
        .maj      (maj),
        .all_zero (all_zero),
        .mixed    (mixed),
        .cap      (cap),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .noise_err(noise_err),
        .frame_err(frame_err),
        .armed    (armed),
        .busy     (busy)
    );
endmodule

// File: rtl/uart_rx_qual_chk.sv
// Module: property checker bound to uart_rx_qual.
// Observes ports plus the arm and busy state driven by the frame machine.
module uart_rx_qual_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en,
    input logic              rx_ready,
    input logic              noise_err,
    input logic              frame_err,
    input logic [DATA_W-1:0] rx_data,
    input logic              armed,
    input logic              busy
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |=> !rx_ready);

    a_r5_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> $past(sample_en));

    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> ($stable(rx_data) && $stable(noise_err) && $stable(frame_err)));

    a_r9_break_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && frame_err && rx_data == '0) |-> !armed);

    a_r8_error_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && frame_err && rx_data != '0) |-> armed);

    a_r1_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed));
endmodule

bind uart_rx_qual uart_rx_qual_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(sample_en),
    .rx_ready (rx_ready),
    .noise_err(noise_err),
    .frame_err(frame_err),
    .rx_data  (rx_data),
    .armed    (armed),
    .busy     (busy)
);

// File: tb/uart_rx_qual_tb.sv
module uart_rx_qual_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       rxd = 1'b1;
    logic       nine_bit = 1'b0;
    logic [8:0] rx_data;
    logic       rx_ready;
    logic       noise_err;
    logic       frame_err;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    int run_len = 0;
    int max_run = 0;
    logic [8:0] last_data;
    logic       last_nf;
    logic       last_fe;
    bit         done = 1'b0;

    uart_rx_qual u_dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
        .nine_bit(nine_bit), .rx_data(rx_data), .rx_ready(rx_ready),
        .noise_err(noise_err), .frame_err(frame_err)
    );

    always #4 clk = ~clk;

    // Sample enable on every other clock, changed away from the active edge.
    always @(negedge clk) sample_en <= ~sample_en;

    // Record strobes and the longest run of rx_ready.
    always @(negedge clk) begin
        if (rx_ready) begin
            strobes   <= strobes + 1;
            last_data <= rx_data;
            last_nf   <= noise_err;
            last_fe   <= frame_err;
            run_len   <= run_len + 1;
            if (run_len + 1 > max_run) max_run <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait for n sample ticks, holding the line at v.
    task automatic hold(input logic v, input int n);
        rxd = v;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!sample_en) @(posedge clk);
            #1;
        end
    endtask

    // One frame; flips sample gidx of bit position gbit (0 start, 1..nb data, nb+1 stop; 99 none).
    task automatic send(input logic [8:0] d, input logic nb9, input logic stopv,
                        input int gbit, input int gidx);
        int nb;
        logic v;
        nb = nb9 ? 9 : 8;
        for (int p = 0; p <= nb + 1; p++) begin
            if (p == 0)           v = 1'b0;
            else if (p == nb + 1) v = stopv;
            else                  v = d[p-1];
            for (int s = 0; s < 16; s++) hold(v ^ ((p == gbit) && (s == gidx)), 1);
        end
    endtask

    task automatic expect_frame(input string req, input int n0, input logic [8:0] d,
                                input logic nf, input logic fe);
        chk({req, " strobe count"}, strobes - n0, 1);
        chk({req, " data"}, last_data, d);
        chk({req, " noise"}, last_nf, nf);
        chk({req, " frame"}, last_fe, fe);
    endtask

    initial begin
        int n0;
        int bad;
        repeat (4) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11 data", rx_data, 0);
        chk("R11 ready", rx_ready, 0);
        chk("R11 flags", {noise_err, frame_err}, 0);
        rst_n = 1'b1;
        hold(1, 20);

        // R4 R6: full 8-bit sweep, clean frames
        nine_bit = 1'b0;
        bad = 0;
        for (int v = 0; v < 256; v++) begin
            n0 = strobes;
            send(9'(v), 1'b0, 1'b1, 99, 0);
            hold(1, 4);
            if (strobes - n0 != 1 || last_data != 9'(v) || last_nf || last_fe) begin
                bad++;
                $display("FAIL R4 value=%0h actual=%0h nf=%0b fe=%0b expected=%0h", v, last_data, last_nf, last_fe, v);
            end
        end
        checks++;
        if (bad != 0) fails++;

        // R4: 9-bit sweep with bit 8 alternating
        nine_bit = 1'b1;
        hold(1, 4);
        bad = 0;
        for (int v = 0; v < 64; v++) begin
            logic [8:0] w;
            w = {v[0], 8'((v * 37) ^ 8'h5A)};
            n0 = strobes;
            send(w, 1'b1, 1'b1, 99, 0);
            hold(1, 4);
            if (strobes - n0 != 1 || last_data != w || last_nf || last_fe) begin
                bad++;
                $display("FAIL R4 nine actual=%0h expected=%0h", last_data, w);
            end
        end
        checks++;
        if (bad != 0) fails++;

        nine_bit = 1'b0;
        hold(1, 4);

        // R2: start with one verification sample high (phase 5)
        n0 = strobes; send(9'h05A, 1'b0, 1'b1, 0, 5); hold(1, 4);
        expect_frame("R2", n0, 9'h05A, 1'b1, 1'b0);

        // R1: two of three verification samples high -> rejected, no strobe
        n0 = strobes; hold(0, 4); hold(1, 30);
        chk("R1 reject count", strobes - n0, 0);
        n0 = strobes; send(9'h0C3, 1'b0, 1'b1, 99, 0); hold(1, 4);
        expect_frame("R1 after reject", n0, 9'h0C3, 1'b0, 1'b0);

        // R3: data bit sample 9 flipped -> value kept, noise set
        n0 = strobes; send(9'h00F, 1'b0, 1'b1, 1, 9); hold(1, 4);
        expect_frame("R3 data", n0, 9'h00F, 1'b1, 1'b0);
        // R3: stop bit sample 8 flipped
        n0 = strobes; send(9'h0A0, 1'b0, 1'b1, 9, 8); hold(1, 4);
        expect_frame("R3 stop", n0, 9'h0A0, 1'b1, 1'b0);
        // R10: flip outside vote window (sample 11) -> no effect
        n0 = strobes; send(9'h033, 1'b0, 1'b1, 3, 11); hold(1, 4);
        expect_frame("R10 outside", n0, 9'h033, 1'b0, 1'b0);

        // R6 R8: framing error then back-to-back start during expected edge
        n0 = strobes;
        send(9'h081, 1'b0, 1'b0, 99, 0);
        send(9'h03C, 1'b0, 1'b1, 99, 0);
        hold(1, 4);
        chk("R8 two strobes", strobes - n0, 2);
        chk("R8 second data", last_data, 9'h03C);
        chk("R8 second fe", last_fe, 0);

        // R7 R9: 8-bit break, line held low well past it
        n0 = strobes; hold(0, 160 + 60);
        expect_frame("R7 break8", n0, 9'h000, 1'b0, 1'b1);
        chk("R9 no restart while low", strobes - n0, 1);
        hold(1, 16);
        n0 = strobes; send(9'h042, 1'b0, 1'b1, 99, 0); hold(1, 4);
        expect_frame("R9 after break", n0, 9'h042, 1'b0, 1'b0);

        // R7 R9: 9-bit break (11 zeros)
        nine_bit = 1'b1; hold(1, 4);
        n0 = strobes; hold(0, 176 + 60);
        expect_frame("R7 break9", n0, 9'h000, 1'b0, 1'b1);
        hold(1, 16);
        n0 = strobes; send(9'h1E7, 1'b1, 1'b1, 99, 0); hold(1, 4);
        expect_frame("R9 after break9", n0, 9'h1E7, 1'b0, 1'b0);

        // R5: strobe never longer than one clock
        chk("R5 pulse width", max_run, 1);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule